// File: doc/BRIEF.md
# Branch-PC Wrong-Path Usefulness Predictor

This block decides whether fetch gating should be vetoed for the branch most recently fetched. It keeps the PC of the latest conditional branch. It also keeps a small table of outstanding cache misses, and each miss is tagged with the branch ID and the branch PC that were current when it was issued. When a misprediction resolves, every tracked miss that is the same age as the resolved branch or younger is flagged as having come from the wrong path.

If the correct path later misses on an address that one of those flagged entries already holds, then the wrong-path work did useful prefetching. The branch PC stored in that entry is then written into a small tag-only set-associative cache. When the gating logic asks for permission to gate, the latest branch PC is looked up in that cache. A hit raises `useful`, which tells the gating logic to keep fetching.

Only tracking and prediction are modelled here. Memory data never passes through the block. Allocation, fill completion and correct-path lookups arrive as single-cycle strobes from the miss-handling logic.

Top module: `wpu_top`

## Requirements
- R1: While reset is asserted and right after it, `latest_pc` is 0, every table entry is free, the usefulness cache is empty, and `useful` is 0 even when `gate_req` is high.
- R2: `latest_pc` takes `br_fetch_pc` at the clock edge where `br_fetch_vld` is high. It holds its value at every other edge.
- R3: An allocated entry starts with its wrong-path flag clear. A correct-path miss that matches an entry which was never marked does not train the cache.
- R4: A resolve marks every valid entry whose branch ID is the same age as `resolve_bid` or younger. Age is the distance ahead of `oldest_bid`, taken modulo 1024 (10-bit IDs that wrap). Entries that are strictly older stay unmarked.
- R5: A correct-path miss whose address matches a marked entry inserts that entry's branch PC into the cache. A later gate request made while `latest_pc` equals that PC returns `useful` = 1.
- R6: Training clears the wrong-path flag of the entry that was hit, so a second correct-path miss on the same entry inserts nothing and does not refresh LRU state.
- R7: The table has 32 entries, and an allocation takes the lowest free entry. An allocation made while all entries are valid is dropped. A fill whose address matches frees the entry, and a freed entry can no longer train.
- R8: `useful` is combinational in the same cycle as `gate_req`. It is 0 whenever `gate_req` is 0, and the lookup always uses `latest_pc`.
- R9: The cache has 4 sets of 4 ways, and the set index is `pc[1:0]`. The replacement policy is true LRU. A new PC fills the lowest invalid way first, and otherwise evicts the least recently used way. An insert and a gate-lookup hit each make the way most recently used.
- R10: Inserting a PC that is already present only refreshes it to most recently used. It never takes a second way.
- R11: When an insert and a gate lookup happen in the same cycle, the insert wins the LRU update port. A lookup of the PC being inserted reports `useful` = 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_fetch_vld | input | 1 | A conditional branch is fetched this cycle |
| br_fetch_pc | input | 16 | PC of the fetched branch |
| latest_pc | output | 16 | Latest branch PC, which travels with the instructions that follow |
| miss_alloc_vld | input | 1 | Allocate a tracked miss |
| miss_alloc_addr | input | 32 | Address of the new miss |
| miss_alloc_bid | input | 10 | Branch ID carried by the missing instruction |
| miss_alloc_pc | input | 16 | Branch PC carried by the missing instruction |
| oldest_bid | input | 10 | Branch ID of the oldest branch in flight, the base for age comparisons |
| resolve_vld | input | 1 | A misprediction has resolved |
| resolve_bid | input | 10 | Branch ID of the mispredicted branch |
| fill_vld | input | 1 | A miss has completed |
| fill_addr | input | 32 | Address of the completed miss |
| cp_miss_vld | input | 1 | Correct-path miss lookup |
| cp_miss_addr | input | 32 | Address of the correct-path miss |
| gate_req | input | 1 | The gating logic wants to gate fetch |
| useful | output | 1 | Veto: the latest branch PC is known to be useful |

## Verification
`latest_pc` and every change to the table and the cache appear one rising edge after the strobe that causes them. A correct-path miss therefore affects a gate lookup made in the following cycle. `useful` is combinational, in the same cycle as `gate_req`, and that includes forwarding of an insert happening in the same cycle. The bench drives its inputs 1 ns after a rising edge and reads outputs at the falling edge of the same cycle. Each register-backed check is made only after the edge that commits the value. A bench-side recency list for every set gives the expected hit or miss for each gate lookup, both in the directed cases and in the seeded random mix.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
    localparam int DEF_PC_W   = 16;
    localparam int DEF_BID_W  = 10;
    localparam int DEF_ADDR_W = 32;

    // source that owns the cache's single replacement-state update port
    typedef enum logic [1:0] {
        TS_NONE   = 2'd0,
        TS_INSERT = 2'd1,
        TS_LOOKUP = 2'd2
    } touch_src_e;
endpackage

// File: rtl/wpu_lbpc.sv
module wpu_lbpc #(
    parameter int PC_W = wpu_pkg::DEF_PC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_vld,
    input  logic [PC_W-1:0] upd_pc,
    output logic [PC_W-1:0] cur_pc
);
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_pc <= '0;
        else if (upd_vld) cur_pc <= upd_pc;
    end
endmodule

// File: rtl/wpu_miss_tbl.sv
module wpu_miss_tbl #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = wpu_pkg::DEF_ADDR_W,
    parameter int PC_W   = wpu_pkg::DEF_PC_W,
    parameter int BID_W  = wpu_pkg::DEF_BID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_vld,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [BID_W-1:0]  alloc_bid,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic [BID_W-1:0]  head_bid,
    input  logic              rslv_vld,
    input  logic [BID_W-1:0]  rslv_bid,
    input  logic              fill_vld,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              cp_vld,
    input  logic [ADDR_W-1:0] cp_addr,
    output logic              trn_vld,
    output logic [PC_W-1:0]   trn_pc
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              e_vld  [DEPTH];
    logic              e_wp   [DEPTH];
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [BID_W-1:0]  e_bid  [DEPTH];
    logic [PC_W-1:0]   e_pc   [DEPTH];

    logic             free_found, hit_found;
    logic [IDX_W-1:0] free_idx, hit_idx;
    logic [BID_W-1:0] rslv_dist;

    assign rslv_dist = rslv_bid - head_bid;

    // lowest free slot and lowest marked address match
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        hit_found  = 1'b0;
        hit_idx    = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!e_vld[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (e_vld[i] && e_wp[i] && (e_addr[i] == cp_addr)) begin
                hit_found = 1'b1;
                hit_idx   = IDX_W'(i);
            end
        end
    end

    assign trn_vld = cp_vld && hit_found;
    assign trn_pc  = e_pc[hit_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [BID_W-1:0] ent_dist;
        logic             not_older;
        assign ent_dist  = e_bid[g] - head_bid;
        assign not_older = (ent_dist >= rslv_dist);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_vld[g]  <= 1'b0;
                e_wp[g]   <= 1'b0;
                e_addr[g] <= '0;
                e_bid[g]  <= '0;
                e_pc[g]   <= '0;
            end else begin
                if (fill_vld && e_vld[g] && (e_addr[g] == fill_addr))
                    e_vld[g] <= 1'b0;
                if (rslv_vld && e_vld[g] && not_older)
                    e_wp[g] <= 1'b1;
                if (trn_vld && (hit_idx == IDX_W'(g)))
                    e_wp[g] <= 1'b0;
                if (alloc_vld && free_found && (free_idx == IDX_W'(g))) begin
                    e_vld[g]  <= 1'b1;
                    e_wp[g]   <= 1'b0;
                    e_addr[g] <= alloc_addr;
                    e_bid[g]  <= alloc_bid;
                    e_pc[g]   <= alloc_pc;
                end
            end
        end
    end
endmodule

// File: rtl/wpu_pc_cache.sv
module wpu_pc_cache #(
    parameter int PC_W = wpu_pkg::DEF_PC_W,
    parameter int SETS = 4,
    parameter int WAYS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_vld,
    input  logic [PC_W-1:0] ins_pc,
    input  logic            lk_vld,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_useful
);
    import wpu_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = PC_W - SET_W;
    localparam int AGE_W = $clog2(WAYS);

    logic [TAG_W-1:0] c_tag [SETS][WAYS];
    logic             c_vld [SETS][WAYS];
    logic [AGE_W-1:0] c_age [SETS][WAYS];

    logic [SET_W-1:0] lk_set, in_set, t_set;
    logic [TAG_W-1:0] lk_tag, in_tag;
    logic             lk_hit, in_hit, in_free;
    logic [AGE_W-1:0] lk_way, in_way, vict, t_way;
    touch_src_e       t_src;

    assign lk_set = lk_pc[SET_W-1:0];
    assign lk_tag = lk_pc[PC_W-1:SET_W];
    assign in_set = ins_pc[SET_W-1:0];
    assign in_tag = ins_pc[PC_W-1:SET_W];

    always_comb begin
        lk_hit  = 1'b0;
        lk_way  = '0;
        in_hit  = 1'b0;
        in_way  = '0;
        in_free = 1'b0;
        vict    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (c_vld[lk_set][w] && (c_tag[lk_set][w] == lk_tag)) begin
                lk_hit = 1'b1;
                lk_way = AGE_W'(w);
            end
            if (c_vld[in_set][w] && (c_tag[in_set][w] == in_tag)) begin
                in_hit = 1'b1;
                in_way = AGE_W'(w);
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!c_vld[in_set][w]) begin
                in_free = 1'b1;
                vict    = AGE_W'(w);
            end
        end
        if (!in_free) begin
            for (int w = 0; w < WAYS; w++)
                if (c_age[in_set][w] == AGE_W'(WAYS - 1)) vict = AGE_W'(w);
        end
    end

    // the insert owns the replacement update when both want it
    always_comb begin
        t_src = TS_NONE;
        t_set = in_set;
        t_way = '0;
        if (ins_vld) begin
            t_src = TS_INSERT;
            t_way = in_hit ? in_way : vict;
        end else if (lk_vld && lk_hit) begin
            t_src = TS_LOOKUP;
            t_set = lk_set;
            t_way = lk_way;
        end
    end

    assign lk_useful = lk_vld && (lk_hit || (ins_vld && (ins_pc == lk_pc)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    c_vld[s][w] <= 1'b0;
                    c_tag[s][w] <= '0;
                    c_age[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            if (t_src != TS_NONE) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (AGE_W'(w) == t_way)
                        c_age[t_set][w] <= '0;
                    else if (c_age[t_set][w] < c_age[t_set][t_way])
                        c_age[t_set][w] <= c_age[t_set][w] + 1'b1;
                end
            end
            if (t_src == TS_INSERT) begin
                c_vld[t_set][t_way] <= 1'b1;
                c_tag[t_set][t_way] <= in_tag;
            end
        end
    end
endmodule

// File: rtl/wpu_top.sv
module wpu_top #(
    parameter int PC_W     = wpu_pkg::DEF_PC_W,
    parameter int BID_W    = wpu_pkg::DEF_BID_W,
    parameter int ADDR_W   = wpu_pkg::DEF_ADDR_W,
    parameter int MT_DEPTH = 32,
    parameter int C_SETS   = 4,
    parameter int C_WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_fetch_vld,
    input  logic [PC_W-1:0]   br_fetch_pc,
    output logic [PC_W-1:0]   latest_pc,
    input  logic              miss_alloc_vld,
    input  logic [ADDR_W-1:0] miss_alloc_addr,
    input  logic [BID_W-1:0]  miss_alloc_bid,
    input  logic [PC_W-1:0]   miss_alloc_pc,
    input  logic [BID_W-1:0]  oldest_bid,
    input  logic              resolve_vld,
    input  logic [BID_W-1:0]  resolve_bid,
    input  logic              fill_vld,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              cp_miss_vld,
    input  logic [ADDR_W-1:0] cp_miss_addr,
    input  logic              gate_req,
    output logic              useful
);
    logic            trn_vld;
    logic [PC_W-1:0] trn_pc;

    wpu_lbpc #(.PC_W(PC_W)) u_lbpc (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_vld (br_fetch_vld),
        .upd_pc  (br_fetch_pc),
        .cur_pc  (latest_pc)
    );

    wpu_miss_tbl #(
        .DEPTH(MT_DEPTH), .ADDR_W(ADDR_W), .PC_W(PC_W), .BID_W(BID_W)
    ) u_mtbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_vld  (miss_alloc_vld),
        .alloc_addr (miss_alloc_addr),
        .alloc_bid  (miss_alloc_bid),
        .alloc_pc   (miss_alloc_pc),
        .head_bid   (oldest_bid),
        .rslv_vld   (resolve_vld),
        .rslv_bid   (resolve_bid),
        .fill_vld   (fill_vld),
        .fill_addr  (fill_addr),
        .cp_vld     (cp_miss_vld),
        .cp_addr    (cp_miss_addr),
        .trn_vld    (trn_vld),
        .trn_pc     (trn_pc)
    );

    wpu_pc_cache #(.PC_W(PC_W), .SETS(C_SETS), .WAYS(C_WAYS)) u_pcc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_vld   (trn_vld),
        .ins_pc    (trn_pc),
        .lk_vld    (gate_req),
        .lk_pc     (latest_pc),
        .lk_useful (useful)
    );
endmodule

// File: rtl/wpu_chk.sv
module wpu_chk #(
    parameter int PC_W = wpu_pkg::DEF_PC_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            br_fetch_vld,
    input logic [PC_W-1:0] br_fetch_pc,
    input logic [PC_W-1:0] latest_pc,
    input logic            gate_req,
    input logic            useful,
    input logic            cp_miss_vld,
    input logic            trn_vld,
    input logic [PC_W-1:0] trn_pc
);
    // R8
    useful_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        useful |-> gate_req);

    // R2
    lbpc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_fetch_vld |=> (latest_pc == $past(br_fetch_pc)));

    // R2
    lbpc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_fetch_vld |=> $stable(latest_pc));

    // R5
    train_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trn_vld |-> cp_miss_vld);

    // R11
    ins_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_req && trn_vld && (trn_pc == latest_pc)) |-> useful);
endmodule

bind wpu_top wpu_chk #(.PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_fetch_vld (br_fetch_vld),
    .br_fetch_pc  (br_fetch_pc),
    .latest_pc    (latest_pc),
    .gate_req     (gate_req),
    .useful       (useful),
    .cp_miss_vld  (cp_miss_vld),
    .trn_vld      (trn_vld),
    .trn_pc       (trn_pc)
);

// File: tb/tb_wpu_top.sv
`timescale 1ns/1ps
module tb_wpu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_fetch_vld = 0;
    logic [15:0] br_fetch_pc = 0;
    logic [15:0] latest_pc;
    logic        miss_alloc_vld = 0;
    logic [31:0] miss_alloc_addr = 0;
    logic [9:0]  miss_alloc_bid = 0;
    logic [15:0] miss_alloc_pc = 0;
    logic [9:0]  oldest_bid = 0;
    logic        resolve_vld = 0;
    logic [9:0]  resolve_bid = 0;
    logic        fill_vld = 0;
    logic [31:0] fill_addr = 0;
    logic        cp_miss_vld = 0;
    logic [31:0] cp_miss_addr = 0;
    logic        gate_req = 0;
    logic        useful;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    wpu_top dut (.*);

    // expected cache contents: per set, most recent first
    logic [15:0] mdl [4][4];
    int          mdl_n [4];

    function automatic bit mdl_has(logic [15:0] pc);
        for (int k = 0; k < mdl_n[pc[1:0]]; k++)
            if (mdl[pc[1:0]][k] == pc) return 1'b1;
        return 1'b0;
    endfunction

    task automatic mdl_touch(logic [15:0] pc);
        int s = int'(pc[1:0]);
        int p = -1;
        for (int k = 0; k < mdl_n[s]; k++) if (mdl[s][k] == pc) p = k;
        if (p < 0) begin
            if (mdl_n[s] < 4) mdl_n[s]++;
            p = mdl_n[s] - 1;
        end
        for (int k = p; k > 0; k--) mdl[s][k] = mdl[s][k-1];
        mdl[s][0] = pc;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        br_fetch_vld = 0; miss_alloc_vld = 0; resolve_vld = 0;
        fill_vld = 0; cp_miss_vld = 0; gate_req = 0;
    endtask

    task automatic op_fetch(logic [15:0] pc);
        br_fetch_vld = 1; br_fetch_pc = pc; step();
    endtask
    task automatic op_alloc(logic [31:0] a, logic [9:0] b, logic [15:0] pc);
        miss_alloc_vld = 1; miss_alloc_addr = a; miss_alloc_bid = b; miss_alloc_pc = pc; step();
    endtask
    task automatic op_resolve(logic [9:0] b);
        resolve_vld = 1; resolve_bid = b; step();
    endtask
    task automatic op_hit(logic [31:0] a);
        cp_miss_vld = 1; cp_miss_addr = a; step();
    endtask
    task automatic op_fill(logic [31:0] a);
        fill_vld = 1; fill_addr = a; step();
    endtask

    // gate lookup for pc; expected value comes from the recency model
    task automatic gate_check(logic [15:0] pc, string req);
        bit e;
        op_fetch(pc);
        gate_req = 1;
        @(negedge clk);
        e = mdl_has(pc);
        chk(useful == e, req, "useful on gate lookup", int'(useful), int'(e));
        step();
        if (e) mdl_touch(pc);
    endtask

    // full training sequence that ends with the entry freed
    task automatic train(logic [15:0] pc, logic [31:0] a);
        op_alloc(a, 10'd30, pc);
        op_resolve(10'd30);
        op_hit(a);
        op_fill(a);
        mdl_touch(pc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 4; s++) mdl_n[s] = 0;
        void'($urandom(32'd2024));
        gate_req = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(latest_pc == 16'h0, "R1", "latest_pc in reset", int'(latest_pc), 0);
        chk(useful == 1'b0, "R1", "useful in reset", int'(useful), 0);
        #1 rst_n = 1;
        step();
        gate_req = 1;
        @(negedge clk);
        chk(useful == 1'b0, "R1", "useful after reset", int'(useful), 0);
        step();

        // R2 latest branch PC load and hold
        op_fetch(16'h1234);
        @(negedge clk);
        chk(latest_pc == 16'h1234, "R2", "latest_pc load", int'(latest_pc), 'h1234);
        step();
        @(negedge clk);
        chk(latest_pc == 16'h1234, "R2", "latest_pc hold", int'(latest_pc), 'h1234);
        step();

        // R3 unmarked entry never trains
        op_alloc(32'h80, 10'd30, 16'h0777);
        op_hit(32'h80);
        op_fill(32'h80);
        gate_check(16'h0777, "R3");

        // R5 basic training then useful
        train(16'h0A0A, 32'h90);
        gate_check(16'h0A0A, "R5");
        // R8 no useful without gate_req
        op_fetch(16'h0A0A);
        @(negedge clk);
        chk(useful == 1'b0, "R8", "useful while gate_req low", int'(useful), 0);
        step();

        // R4 older entry not marked
        op_alloc(32'h400, 10'd5, 16'h0C03);
        op_resolve(10'd9);
        op_hit(32'h400);
        op_fill(32'h400);
        gate_check(16'h0C03, "R4");
        // R4 wrap-around: younger after wrap is marked, older before wrap is not
        oldest_bid = 10'd1000;
        op_alloc(32'h500, 10'd3, 16'h0D03);
        op_alloc(32'h600, 10'd1010, 16'h0E00);
        op_resolve(10'd1020);
        op_hit(32'h500);
        op_hit(32'h600);
        op_fill(32'h500);
        op_fill(32'h600);
        oldest_bid = 10'd0;
        mdl_touch(16'h0D03);
        gate_check(16'h0D03, "R4");
        gate_check(16'h0E00, "R4");

        // R6 trains once; second hit does not refresh LRU
        op_alloc(32'h100, 10'd20, 16'h0101);
        op_resolve(10'd20);
        op_hit(32'h100);
        mdl_touch(16'h0101);
        train(16'h0201, 32'hA0);
        train(16'h0301, 32'hA4);
        train(16'h0401, 32'hA8);
        op_hit(32'h100);
        train(16'h0501, 32'hAC);
        chk(mdl_has(16'h0101) == 1'b0, "R6", "model eviction", 1, 0);
        gate_check(16'h0101, "R6");
        gate_check(16'h0201, "R6");
        op_fill(32'h100);

        // R9 / R10 LRU with duplicate insert
        train(16'h1100, 32'hB0);
        train(16'h1200, 32'hB4);
        train(16'h1300, 32'hB8);
        train(16'h1400, 32'hBC);
        train(16'h1100, 32'hC0);
        train(16'h1500, 32'hC4);
        gate_check(16'h1200, "R9");
        gate_check(16'h1100, "R10");
        gate_check(16'h1300, "R9");
        gate_check(16'h1400, "R9");

        // R7 full table drops allocation
        for (int i = 0; i < 32; i++) op_alloc(32'h1000 + i, 10'd30, 16'h0F0F);
        op_alloc(32'h2000, 10'd30, 16'h0A02);
        op_resolve(10'd30);
        op_hit(32'h2000);
        gate_check(16'h0A02, "R7");
        for (int i = 0; i < 32; i++) op_fill(32'h1000 + i);
        // R7 fill frees entry
        op_alloc(32'h3000, 10'd30, 16'h0B02);
        op_resolve(10'd30);
        op_fill(32'h3000);
        op_hit(32'h3000);
        gate_check(16'h0B02, "R7");
        train(16'h0A02, 32'h2000);
        gate_check(16'h0A02, "R7");

        // R11 insert and lookup in the same cycle
        op_alloc(32'h700, 10'd30, 16'h0123);
        op_resolve(10'd30);
        op_fetch(16'h0123);
        cp_miss_vld = 1; cp_miss_addr = 32'h700; gate_req = 1;
        @(negedge clk);
        chk(useful == 1'b1, "R11", "forwarded insert", int'(useful), 1);
        step();
        mdl_touch(16'h0123);
        op_fill(32'h700);
        gate_check(16'h0123, "R11");

        // R5 / R9 seeded random mix
        for (int it = 0; it < 300; it++) begin
            int r = int'($urandom % 1000);
            logic [15:0] pc = 16'h4000 | 16'((r % 6) << 2) | 16'((r / 7) % 4);
            if ($urandom % 2 == 0) train(pc, 32'h8000 + 32'(it));
            else gate_check(pc, "R9");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule